// File: doc/BRIEF.md
# Dual-Agent Broadside Register Scratchpad

This block is a small shared store that sits between two agents. Each agent has its own register file. It offers a set of register banks that either agent can write from, or read into, its own registers. Each request moves a contiguous run of registers in one clock cycle over a path as wide as a whole register file. This lets one agent hand a block of words to the other without any word-serial transfer.

A request carries a bank identifier, the index of the first register and a length in bytes. Each agent presents its full register file on a flattened input bus, where register r sits at bits [32r+31:32r]. A store copies the selected registers into the same word positions of the chosen bank at the next clock edge. A load returns the selected bank words combinationally on a flattened output bus in the same cycle, with a per-register mask. The agent captures them at that edge. The two agents may issue requests in the same cycle, and the block resolves the collisions between them.

Top module: `scratch_xchg`

## Requirements
- R1: The block holds three banks of 30 words of 32 bits each. Reset (rst_n low) clears every word to zero, so a load after reset returns zeros.
- R2: Bank identifier 10 selects bank 0, identifier 11 selects bank 1 and identifier 12 selects bank 2. A store into one bank leaves the other two unchanged.
- R3: A request with any other identifier raises the agent's err output in that cycle. It stores nothing, and it returns an all-zero mask and all-zero data.
- R4: A store (req=1, store=1) writes register r of the agent's input bus into word r of the bank at the next rising edge, for every r in the selected range. Words outside the range keep their values.
- R5: A load (req=1, store=0) sets bit r of ld_mask and drives word r of ld_data with bank word r for every r in the range, combinationally in the request cycle. All other mask bits and data words are zero.
- R6: The range starts at the start index and spans ceil(bytes/4) registers. A count of 32 moves 8 registers, a count of 5 moves 2, and a count of 0 moves none.
- R7: Any part of a range past register 29 is dropped, and a start index of 30 or more selects nothing.
- R8: Data that one agent stores is returned to the other agent's load of that bank in any later cycle.
- R9: If one agent stores and the other loads the same bank in the same cycle, the load returns the newly stored words.
- R10: If both agents store to the same bank in the same cycle, agent 1's data wins on the registers that both ranges cover. The registers that only one range covers take that agent's data.
- R11: With req low, an agent's ld_mask, ld_data and err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a0_req | input | 1 | Agent 0 request valid |
| a0_store | input | 1 | Agent 0: 1 = store to bank, 0 = load from bank |
| a0_bank | input | 8 | Agent 0 bank identifier |
| a0_start | input | 5 | Agent 0 first register index |
| a0_bytes | input | 7 | Agent 0 transfer length in bytes |
| a0_regs | input | 960 | Agent 0 register file, register r at bits [32r+31:32r] |
| a0_ld_data | output | 960 | Agent 0 load data, same layout |
| a0_ld_mask | output | 30 | Agent 0 loaded-register mask |
| a0_err | output | 1 | Agent 0 bad bank identifier |
| a1_req | input | 1 | Agent 1 request valid |
| a1_store | input | 1 | Agent 1: 1 = store to bank, 0 = load from bank |
| a1_bank | input | 8 | Agent 1 bank identifier |
| a1_start | input | 5 | Agent 1 first register index |
| a1_bytes | input | 7 | Agent 1 transfer length in bytes |
| a1_regs | input | 960 | Agent 1 register file |
| a1_ld_data | output | 960 | Agent 1 load data |
| a1_ld_mask | output | 30 | Agent 1 loaded-register mask |
| a1_err | output | 1 | Agent 1 bad bank identifier |

## Verification
The properties assume that request fields are stable and known whenever req is high and rst_n is released. They do not assume anything about which agent collides with which. The bench drives every field one time unit after a rising edge and clears all requests after each edge. This means no request lingers into an unintended cycle and no field changes near an edge. Collisions are applied on purpose, with store/load and store/store pairs on the same bank.

// File: rtl/scratch_xchg.sv
module scratch_xchg #(
  parameter int NBANKS    = 3,
  parameter int NREGS     = 30,
  parameter int DW        = 32,
  parameter int BANK_BASE = 10,
  parameter int IDW       = 8,
  parameter int IXW       = 5,
  parameter int BCW       = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a0_req,
  input  logic                a0_store,
  input  logic [IDW-1:0]      a0_bank,
  input  logic [IXW-1:0]      a0_start,
  input  logic [BCW-1:0]      a0_bytes,
  input  logic [NREGS*DW-1:0] a0_regs,
  output logic [NREGS*DW-1:0] a0_ld_data,
  output logic [NREGS-1:0]    a0_ld_mask,
  output logic                a0_err,
  input  logic                a1_req,
  input  logic                a1_store,
  input  logic [IDW-1:0]      a1_bank,
  input  logic [IXW-1:0]      a1_start,
  input  logic [BCW-1:0]      a1_bytes,
  input  logic [NREGS*DW-1:0] a1_regs,
  output logic [NREGS*DW-1:0] a1_ld_data,
  output logic [NREGS-1:0]    a1_ld_mask,
  output logic                a1_err
);

  localparam int FW  = NREGS * DW;
  localparam int BSW = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  logic [1:0]       req, st, hit;
  logic [IDW-1:0]   bk  [2];
  logic [IXW-1:0]   beg [2];
  logic [BCW-1:0]   len [2];
  logic [FW-1:0]    src [2];
  logic [BSW-1:0]   sel [2];
  logic [NREGS-1:0] rng [2];
  logic [NREGS-1:0] msk [2];
  logic [FW-1:0]    ld  [2];

  logic [DW-1:0] mem [NBANKS][NREGS];
  logic [DW-1:0] nxt [NBANKS][NREGS];

  assign req = {a1_req, a0_req};
  assign st  = {a1_store, a0_store};
  assign bk[0]  = a0_bank;   assign bk[1]  = a1_bank;
  assign beg[0] = a0_start;  assign beg[1] = a1_start;
  assign len[0] = a0_bytes;  assign len[1] = a1_bytes;
  assign src[0] = a0_regs;   assign src[1] = a1_regs;

  always_comb begin
    for (int a = 0; a < 2; a++) begin
      int s, w, off;
      s   = int'(beg[a]);
      w   = (int'(len[a]) + 3) / 4;
      off = int'(bk[a]) - BANK_BASE;
      hit[a] = (off >= 0) && (off < NBANKS);
      sel[a] = BSW'(hit[a] ? off : 0);
      for (int r = 0; r < NREGS; r++)
        rng[a][r] = (r >= s) && (r < s + w);
    end
  end

  always_comb begin
    nxt = mem;
    for (int a = 0; a < 2; a++)
      if (req[a] && st[a] && hit[a])
        for (int r = 0; r < NREGS; r++)
          if (rng[a][r]) nxt[sel[a]][r] = src[a][r*DW +: DW];
  end

  always_comb begin
    for (int a = 0; a < 2; a++) begin
      msk[a] = '0;
      ld[a]  = '0;
      if (req[a] && !st[a] && hit[a])
        for (int r = 0; r < NREGS; r++)
          if (rng[a][r]) begin
            msk[a][r]         = 1'b1;
            ld[a][r*DW +: DW] = nxt[sel[a]][r];
          end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANKS; b++)
        for (int r = 0; r < NREGS; r++)
          mem[b][r] <= '0;
    end else begin
      mem <= nxt;
    end
  end

  assign a0_ld_data = ld[0];
  assign a1_ld_data = ld[1];
  assign a0_ld_mask = msk[0];
  assign a1_ld_mask = msk[1];
  assign a0_err     = req[0] && !hit[0];
  assign a1_err     = req[1] && !hit[1];

endmodule

// File: rtl/scratch_xchg_chk.sv
module scratch_xchg_chk #(
  parameter int NREGS = 30,
  parameter int IDW   = 8,
  parameter int IXW   = 5,
  parameter int BCW   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a0_req,
  input logic             a0_store,
  input logic [IDW-1:0]   a0_bank,
  input logic [IXW-1:0]   a0_start,
  input logic [BCW-1:0]   a0_bytes,
  input logic [NREGS-1:0] a0_ld_mask,
  input logic             a0_err,
  input logic             a1_req,
  input logic             a1_store,
  input logic [IDW-1:0]   a1_bank,
  input logic [IXW-1:0]   a1_start,
  input logic [BCW-1:0]   a1_bytes,
  input logic [NREGS-1:0] a1_ld_mask,
  input logic             a1_err
);

  p_err_nomove_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a0_err |-> a0_ld_mask == '0) and (a1_err |-> a1_ld_mask == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!a0_req |-> (a0_ld_mask == '0 && !a0_err)) and
    (!a1_req |-> (a1_ld_mask == '0 && !a1_err)));

  p_store_nomask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((a0_req && a0_store) |-> a0_ld_mask == '0) and
    ((a1_req && a1_store) |-> a1_ld_mask == '0));

  p_word_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(a0_ld_mask) <= (int'(a0_bytes) + 3) / 4) and
    ($countones(a1_ld_mask) <= (int'(a1_bytes) + 3) / 4));

  p_range_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((a0_ld_mask & ~({NREGS{1'b1}} << a0_start)) == '0) and
    ((a1_ld_mask & ~({NREGS{1'b1}} << a1_start)) == '0));

  p_known_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((a0_ld_mask != '0) |-> (a0_bank >= 8'd10 && a0_bank <= 8'd12)) and
    ((a1_ld_mask != '0) |-> (a1_bank >= 8'd10 && a1_bank <= 8'd12)));

endmodule

bind scratch_xchg scratch_xchg_chk #(.NREGS(NREGS), .IDW(IDW), .IXW(IXW), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a0_req(a0_req), .a0_store(a0_store), .a0_bank(a0_bank), .a0_start(a0_start),
  .a0_bytes(a0_bytes), .a0_ld_mask(a0_ld_mask), .a0_err(a0_err),
  .a1_req(a1_req), .a1_store(a1_store), .a1_bank(a1_bank), .a1_start(a1_start),
  .a1_bytes(a1_bytes), .a1_ld_mask(a1_ld_mask), .a1_err(a1_err));

// File: tb/scratch_xchg_test.sv
module scratch_xchg_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         a0_req, a0_store, a1_req, a1_store;
  logic [7:0]   a0_bank, a1_bank;
  logic [4:0]   a0_start, a1_start;
  logic [6:0]   a0_bytes, a1_bytes;
  logic [959:0] a0_regs, a1_regs, a0_ld_data, a1_ld_data;
  logic [29:0]  a0_ld_mask, a1_ld_mask;
  logic         a0_err, a1_err;

  int nvec = 0;
  int nbad = 0;

  scratch_xchg uut (
    .clk(clk), .rst_n(rst_n),
    .a0_req(a0_req), .a0_store(a0_store), .a0_bank(a0_bank), .a0_start(a0_start),
    .a0_bytes(a0_bytes), .a0_regs(a0_regs), .a0_ld_data(a0_ld_data),
    .a0_ld_mask(a0_ld_mask), .a0_err(a0_err),
    .a1_req(a1_req), .a1_store(a1_store), .a1_bank(a1_bank), .a1_start(a1_start),
    .a1_bytes(a1_bytes), .a1_regs(a1_regs), .a1_ld_data(a1_ld_data),
    .a1_ld_mask(a1_ld_mask), .a1_err(a1_err));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    a0_req = 0; a0_store = 0; a0_bank = 0; a0_start = 0; a0_bytes = 0;
    a1_req = 0; a1_store = 0; a1_bank = 0; a1_start = 0; a1_bytes = 0;
  endtask

  task automatic fill(int ag, logic [31:0] seed);
    for (int r = 0; r < 30; r++)
      if (ag == 0) a0_regs[r*32 +: 32] = seed + r;
      else         a1_regs[r*32 +: 32] = seed + r;
  endtask

  task automatic issue(int ag, bit store, logic [7:0] bank, logic [4:0] start, logic [6:0] bytes);
    if (ag == 0) begin
      a0_req = 1; a0_store = store; a0_bank = bank; a0_start = start; a0_bytes = bytes;
    end else begin
      a1_req = 1; a1_store = store; a1_bank = bank; a1_start = start; a1_bytes = bytes;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    idle_all();
  endtask

  function automatic logic [31:0] word(int ag, int r);
    return (ag == 0) ? a0_ld_data[r*32 +: 32] : a1_ld_data[r*32 +: 32];
  endfunction

  function automatic logic [31:0] mask(int ag);
    return (ag == 0) ? {2'b0, a0_ld_mask} : {2'b0, a1_ld_mask};
  endfunction

  function automatic logic [31:0] err(int ag);
    return (ag == 0) ? {31'b0, a0_err} : {31'b0, a1_err};
  endfunction

  task automatic t_reset();
    issue(0, 0, 8'd10, 5'd0, 7'd120);
    #1;
    check("R1 R5 reset mask", mask(0), 32'h3FFF_FFFF);
    for (int r = 0; r < 30; r++) check("R1 reset word", word(0, r), 32'h0);
    step();
  endtask

  task automatic t_store_load();
    fill(1, 32'h1000);
    issue(1, 1, 8'd11, 5'd16, 7'd32);
    #1;
    check("R4 store gives no mask", mask(1), 32'h0);
    step();
    issue(0, 0, 8'd11, 5'd0, 7'd120);
    #1;
    for (int r = 0; r < 30; r++)
      check("R8 R6 cross-agent load", word(0, r), (r >= 16 && r < 24) ? 32'h1000 + r : 32'h0);
    step();
  endtask

  task automatic t_round();
    fill(0, 32'h2000);
    issue(0, 1, 8'd12, 5'd3, 7'd5);
    step();
    fill(0, 32'h2800);
    issue(0, 1, 8'd12, 5'd10, 7'd0);
    step();
    issue(1, 0, 8'd12, 5'd0, 7'd120);
    #1;
    for (int r = 0; r < 30; r++)
      check("R6 rounded range", word(1, r), (r == 3 || r == 4) ? 32'h2000 + r : 32'h0);
    step();
    issue(1, 0, 8'd12, 5'd0, 7'd0);
    #1;
    check("R6 zero bytes mask", mask(1), 32'h0);
    step();
  endtask

  task automatic t_clip();
    fill(0, 32'h3000);
    issue(0, 1, 8'd10, 5'd26, 7'd32);
    step();
    issue(0, 0, 8'd10, 5'd26, 7'd32);
    #1;
    check("R7 clipped mask", mask(0), 32'h3C00_0000);
    for (int r = 26; r < 30; r++) check("R7 clipped word", word(0, r), 32'h3000 + r);
    step();
    issue(0, 0, 8'd10, 5'd30, 7'd32);
    #1;
    check("R7 start beyond end", mask(0), 32'h0);
    step();
  endtask

  task automatic t_badid();
    fill(0, 32'h4000);
    issue(0, 1, 8'd13, 5'd0, 7'd120);
    #1;
    check("R3 err on id 13", err(0), 32'h1);
    step();
    issue(1, 0, 8'd9, 5'd0, 7'd120);
    #1;
    check("R3 err on id 9", err(1), 32'h1);
    check("R3 no mask on bad id", mask(1), 32'h0);
    check("R3 no data on bad id", word(1, 0), 32'h0);
    step();
    issue(0, 0, 8'd10, 5'd0, 7'd120);
    #1;
    check("R3 no err on good id", err(0), 32'h0);
    for (int r = 0; r < 30; r++)
      check("R2 R3 bank 0 content", word(0, r), (r >= 26) ? 32'h3000 + r : 32'h0);
    step();
  endtask

  task automatic t_bypass();
    fill(1, 32'h5000);
    issue(1, 1, 8'd10, 5'd0, 7'd16);
    issue(0, 0, 8'd10, 5'd0, 7'd16);
    #1;
    check("R9 bypass mask", mask(0), 32'hF);
    for (int r = 0; r < 4; r++) check("R9 bypass a1->a0", word(0, r), 32'h5000 + r);
    step();
    fill(0, 32'h5100);
    issue(0, 1, 8'd12, 5'd3, 7'd8);
    issue(1, 0, 8'd12, 5'd3, 7'd8);
    #1;
    check("R9 bypass a0->a1 r3", word(1, 3), 32'h5103);
    check("R9 bypass a0->a1 r4", word(1, 4), 32'h5104);
    step();
  endtask

  task automatic t_conflict();
    fill(0, 32'h6000);
    fill(1, 32'h7000);
    issue(0, 1, 8'd11, 5'd0, 7'd40);
    issue(1, 1, 8'd11, 5'd5, 7'd40);
    step();
    issue(0, 0, 8'd11, 5'd0, 7'd120);
    #1;
    for (int r = 0; r < 30; r++) begin
      logic [31:0] e;
      if (r < 5)       e = 32'h6000 + r;
      else if (r < 15) e = 32'h7000 + r;
      else if (r >= 16 && r < 24) e = 32'h1000 + r;
      else             e = 32'h0;
      check("R10 store-store priority", word(0, r), e);
    end
    step();
  endtask

  task automatic t_idle();
    #1;
    check("R11 idle mask a0", mask(0), 32'h0);
    check("R11 idle mask a1", mask(1), 32'h0);
    check("R11 idle err a0", err(0), 32'h0);
    check("R11 idle data a1", word(1, 0), 32'h0);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 0;
    a0_regs = '0;
    a1_regs = '0;
    idle_all();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    t_reset();
    t_store_load();
    t_round();
    t_clip();
    t_badid();
    t_bypass();
    t_conflict();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule